// File: doc/BRIEF.md
# Keyed Nonvolatile Write Sequencer

This block controls writes to a small on-chip data word array that behaves like EEPROM. Software reaches it through a simple register bus. The bus has a write strobe, a register select, 16-bit write data, a word pointer used by latch writes, and a combinational read port. The registers are:

- a control word holding the operation code, a write-enable bit, a start/busy bit and a sticky completion flag;
- a key register;
- an address register;
- a read window onto the addressed array word;
- sixteen data latches.

An erase or program cycle starts only when all three of these hold:

- two unlock keys arrived in order;
- the bus write right after them sets the start bit;
- write-enable was already set by an earlier write.

The cycle then runs in the background for a fixed number of clocks, and the bus stays usable. When the cycle ends, the start bit drops and the completion flag rises. Programming can only clear bits, so a word must be erased before it can take an arbitrary value.

Top module: `nvm_wr_seq`

## Requirements
- R1: After reset, the control word reads 0x0000 and every array word reads 0xFFFF.
- R2: A cycle starts only if the three bus writes just before the start are, in order: key select (1) with low byte 0x55, key select with low byte 0xAA, then a control write (select 0) with bit 15 set. Any other write in between, or the keys in the wrong order, cancels the unlock.
- R3: Bit 14 (write-enable) must already be 1 before the start write. A start write that sets bits 15 and 14 together while enable is clear starts nothing, but it does leave enable at 1. Every start attempt uses up the unlock, whether it is accepted or rejected.
- R4: After an accepted start, bit 15 reads 1 for exactly CYCLE_CLKS clock cycles and then returns to 0 by itself. Bit 13 (done) becomes 1 in the cycle where bit 15 drops.
- R5: The done bit stays 1 until a control write has bit 13 at 0. A control write with bit 13 at 1 leaves it set.
- R6: Write-enable changes only through control writes. Clearing it during a cycle does not stop or alter that cycle.
- R7: Operation code 0x1 (bits 3:0) erases the word at the address register to 0xFFFF.
- R8: Operation code 0x4 (control value 0x4004 with enable) programs one word. The new word is the old word ANDed with the latch whose index is the address's low four bits.
- R9: Operation code 0x5 programs all sixteen words of the 16-word block that holds the address. Word i of the block is ANDed with latch i.
- R10: A latch write (select 4) stores the data in latch bus_ptr[3:0] and loads the address register with bus_ptr. Select 2 loads the address from data bits. Select 3 reads the addressed array word. Select 4 reads the latch indexed by the address. Select 1 reads 0.
- R11: A start write whose operation code is not 0x1, 0x4 or 0x5 starts nothing.
- R12: The operation, address and latch contents are captured at the start. Latch, address and control writes made during a running cycle do not change what that cycle writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_sel | input | 3 | Register select: 0 control, 1 key, 2 address, 3 array window, 4 latch |
| bus_wdata | input | 16 | Write data |
| bus_ptr | input | ADDR_W | Word pointer for latch writes |
| bus_rdata | output | 16 | Read data of the selected register |

## Verification
The checker assumes that each bus write is a single-cycle strobe whose select and data are stable in that cycle, and that reset is asserted before the first checked edge. The bench changes inputs only on the falling clock edge and drives one write per cycle at most. It reads back through the select port between writes, so every write-enable change and every start-bit rise has a bus write in the previous cycle. With the cycle length shortened, the bench can run to completion and the run-length counter in the checker can close every window.

// File: rtl/nvm_pkg.sv
// Shared definitions for the keyed nonvolatile write sequencer.
// Assumes a 16-bit register bus; the control-word bit positions are fixed.
package nvm_pkg;
    localparam int WORD_W     = 16;
    localparam int CTRL_START = 15;
    localparam int CTRL_WEN   = 14;
    localparam int CTRL_DONE  = 13;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam logic [3:0] OP_ERASE = 4'h1;
    localparam logic [3:0] OP_WORD  = 4'h4;
    localparam logic [3:0] OP_BLOCK = 4'h5;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_KEY   = 3'd1,
        SEL_ADDR  = 3'd2,
        SEL_MEM   = 3'd3,
        SEL_LATCH = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_e;

    function automatic logic op_known(input logic [3:0] op);
        return (op == OP_ERASE) || (op == OP_WORD) || (op == OP_BLOCK);
    endfunction
endpackage

// File: rtl/nvm_unlock.sv
// Unlock tracker: follows the two-key order on bus writes.
// Assumes at most one bus write per cycle. Any write that is not the
// expected next step returns to idle; the armed state lasts for one write only.
module nvm_unlock
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [2:0] bus_sel,
    input  logic [7:0] key_byte,
    output logic       armed
);
    unlock_e st_q;
    logic    key_wr;

    assign key_wr = bus_wr && (bus_sel == SEL_KEY);

    // Advance or drop the key sequence on each bus write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= UL_IDLE;
        end else if (bus_wr) begin
            case (st_q)
                UL_IDLE: st_q <= (key_wr && key_byte == KEY_FIRST)  ? UL_HALF  : UL_IDLE;
                UL_HALF: st_q <= (key_wr && key_byte == KEY_SECOND) ? UL_ARMED : UL_IDLE;
                default: st_q <= UL_IDLE;
            endcase
        end
    end

    assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/nvm_timer.sv
// Cycle timer: holds busy for exactly CYCLE_CLKS clocks after a launch
// and flags the final busy cycle with finish. Assumes no launch while busy.
module nvm_timer #(
    parameter int CYCLE_CLKS = 100000,
    localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic finish
);
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign finish = busy_q && (cnt_q == '0);
    assign busy   = busy_q;

    // Load on launch, count down while busy, drop on the last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(CYCLE_CLKS - 1);
        end else if (finish) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/nvm_array.sv
// Word array with data latches. Latches are written from the bus. At launch
// the operation, address and all latches are captured; at finish the
// captured operation is applied (erase to ones, or AND-program one word or
// one latch-sized block). Assumes DEPTH is a multiple of LATCHES and larger.
module nvm_array
    import nvm_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int LATCHES = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LAT_W  = $clog2(LATCHES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_we,
    input  logic [LAT_W-1:0]  lat_idx,
    input  logic [WORD_W-1:0] lat_data,
    input  logic              launch,
    input  logic [3:0]        op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              finish,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] lat_rdata
);
    logic [WORD_W-1:0] lat_q    [LATCHES];
    logic [WORD_W-1:0] snap_lat [LATCHES];
    logic [WORD_W-1:0] mem_w    [DEPTH];
    logic [3:0]        snap_op;
    logic [ADDR_W-1:0] snap_addr;

    // Bus writes into the data latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LATCHES; i++) lat_q[i] <= '1;
        end else if (lat_we) begin
            lat_q[lat_idx] <= lat_data;
        end
    end

    // Capture the operation, its target and the latch image at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_op   <= '0;
            snap_addr <= '0;
            for (int i = 0; i < LATCHES; i++) snap_lat[i] <= '1;
        end else if (launch) begin
            snap_op   <= op_in;
            snap_addr <= addr_in;
            snap_lat  <= lat_q;
        end
    end

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
        logic [WORD_W-1:0] word_q;
        logic              word_hit;
        logic              blk_hit;

        assign word_hit = (snap_addr == WA);
        assign blk_hit  = (snap_addr[ADDR_W-1:LAT_W] == WA[ADDR_W-1:LAT_W]);

        // Apply the captured operation to this word at finish
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (finish) begin
                if (snap_op == OP_ERASE && word_hit)
                    word_q <= '1;
                else if ((snap_op == OP_WORD && word_hit) ||
                         (snap_op == OP_BLOCK && blk_hit))
                    word_q <= word_q & snap_lat[WA[LAT_W-1:0]];
            end
        end

        assign mem_w[w] = word_q;
    end

    assign mem_rdata = mem_w[rd_addr];
    assign lat_rdata = lat_q[rd_addr[LAT_W-1:0]];
endmodule

// File: rtl/nvm_wr_seq.sv
// Keyed nonvolatile write sequencer top. It decodes the register bus, holds
// the control, enable, done and address state, gates the start through the
// unlock tracker and the enable bit, and times the background cycle.
// Assumes one bus write per cycle; reads are combinational from bus_sel.
module nvm_wr_seq
    import nvm_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int LATCHES    = 16,
    parameter int CYCLE_CLKS = 100000,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int LAT_W     = $clog2(LATCHES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_sel,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_ptr,
    output logic [WORD_W-1:0] bus_rdata
);
    logic              wen_q;
    logic              done_q;
    logic [3:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              armed;
    logic              start_q;
    logic              finish;
    logic              ctrl_wr;
    logic              launch;
    logic [WORD_W-1:0] mem_rdata;
    logic [WORD_W-1:0] lat_rdata;

    assign ctrl_wr = bus_wr && (bus_sel == SEL_CTRL);
    assign launch  = ctrl_wr && armed && bus_wdata[CTRL_START] && wen_q &&
                     !start_q && op_known(bus_wdata[3:0]);

    nvm_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_sel  (bus_sel),
        .key_byte (bus_wdata[7:0]),
        .armed    (armed)
    );

    nvm_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (start_q),
        .finish (finish)
    );

    nvm_array #(.DEPTH(DEPTH), .LATCHES(LATCHES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_we    (bus_wr && (bus_sel == SEL_LATCH)),
        .lat_idx   (bus_ptr[LAT_W-1:0]),
        .lat_data  (bus_wdata),
        .launch    (launch),
        .op_in     (bus_wdata[3:0]),
        .addr_in   (addr_q),
        .finish    (finish),
        .rd_addr   (addr_q),
        .mem_rdata (mem_rdata),
        .lat_rdata (lat_rdata)
    );

    // Software-owned control fields: enable and operation code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
            op_q  <= '0;
        end else if (ctrl_wr) begin
            wen_q <= bus_wdata[CTRL_WEN];
            op_q  <= bus_wdata[3:0];
        end
    end

    // Sticky completion flag: hardware sets, a control write with the bit low clears
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (finish)
            done_q <= 1'b1;
        else if (ctrl_wr && !bus_wdata[CTRL_DONE])
            done_q <= 1'b0;
    end

    // Address register: loaded directly or by the pointer of a latch write
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (bus_wr && bus_sel == SEL_ADDR)
            addr_q <= bus_wdata[ADDR_W-1:0];
        else if (bus_wr && bus_sel == SEL_LATCH)
            addr_q <= bus_ptr;
    end

    // Read multiplexer for the selected register
    always_comb begin
        case (bus_sel)
            SEL_CTRL:  bus_rdata = {start_q, wen_q, done_q, 9'd0, op_q};
            SEL_ADDR:  bus_rdata = WORD_W'(addr_q);
            SEL_MEM:   bus_rdata = mem_rdata;
            SEL_LATCH: bus_rdata = lat_rdata;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nvm_wr_seq_chk.sv
// Property checker for nvm_wr_seq, attached by bind. Assumes bus inputs
// change away from the clock edge and reset is asserted at start.
module nvm_wr_seq_chk #(
    parameter int CYCLE_CLKS = 100000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [2:0] bus_sel,
    input logic       wr_start,
    input logic       wr_done,
    input logic       start_bit,
    input logic       wen_bit,
    input logic       done_bit,
    input logic       armed
);
    int run_len;

    // Count consecutive cycles with the start bit high
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= 0;
        else if (start_bit)
            run_len <= run_len + 1;
        else
            run_len <= 0;
    end

    // R2
    start_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_bit) |-> $past(armed && bus_wr && bus_sel == 3'd0 && wr_start));

    // R3
    start_needs_prior_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_bit) |-> $past(wen_bit));

    // R4
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_bit) |-> done_bit);

    // R4
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_bit) |-> run_len == CYCLE_CLKS);

    // R4
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= CYCLE_CLKS);

    // R5
    done_clear_by_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_bit) |-> $past(bus_wr && bus_sel == 3'd0 && !wr_done));

    // R6
    wen_sw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wen_bit) |-> $past(bus_wr && bus_sel == 3'd0));
endmodule

bind nvm_wr_seq nvm_wr_seq_chk #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .wr_start  (bus_wdata[15]),
    .wr_done   (bus_wdata[13]),
    .start_bit (start_q),
    .wen_bit   (wen_q),
    .done_bit  (done_q),
    .armed     (armed)
);

// File: tb/sim_nvm_wr_seq.sv
// Bench: behavioural reference model compared with bus_rdata on every clock.
module sim_nvm_wr_seq;
    localparam int CYC   = 20;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [5:0]  bus_ptr = 6'd0;
    logic [15:0] bus_rdata;

    always #10 clk = ~clk;

    nvm_wr_seq #(.DEPTH(DEPTH), .LATCHES(16), .CYCLE_CLKS(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_ptr(bus_ptr), .bus_rdata(bus_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_req = "R1";
    logic [15:0] last_rd;

    // reference model state
    int m_start, m_wen, m_done, m_op, m_addr, m_cnt, key_st;
    int s_op, s_addr;
    logic [15:0] mem [DEPTH];
    logic [15:0] lat [16];
    logic [15:0] s_lat [16];

    function automatic logic [15:0] model_rd(input logic [2:0] s);
        case (s)
            3'd0: return {m_start[0], m_wen[0], m_done[0], 9'd0, 4'(m_op)};
            3'd2: return 16'(m_addr);
            3'd3: return mem[m_addr];
            3'd4: return lat[m_addr % 16];
            default: return 16'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_start = 0; m_wen = 0; m_done = 0; m_op = 0; m_addr = 0;
        m_cnt = 0; key_st = 0; s_op = 0; s_addr = 0;
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;
        for (int i = 0; i < 16; i++) begin lat[i] = 16'hFFFF; s_lat[i] = 16'hFFFF; end
    endtask

    task automatic model_step(input logic w, input logic [2:0] s,
                              input logic [15:0] d, input logic [5:0] p);
        bit fin, go;
        int op;
        op  = int'(d[3:0]);
        fin = (m_start != 0) && (m_cnt == 0);
        go  = w && key_st == 2 && s == 3'd0 && d[15] && m_wen != 0 &&
              m_start == 0 && (op == 1 || op == 4 || op == 5);
        if (w) begin
            if (key_st == 0)      key_st = (s == 3'd1 && d[7:0] == 8'h55) ? 1 : 0;
            else if (key_st == 1) key_st = (s == 3'd1 && d[7:0] == 8'hAA) ? 2 : 0;
            else                  key_st = 0;
        end
        if (fin) m_done = 1;
        else if (w && s == 3'd0 && !d[13]) m_done = 0;
        if (fin) begin
            if (s_op == 1) mem[s_addr] = 16'hFFFF;
            else if (s_op == 4) mem[s_addr] = mem[s_addr] & s_lat[s_addr % 16];
            else if (s_op == 5)
                for (int i = 0; i < 16; i++)
                    mem[(s_addr / 16) * 16 + i] = mem[(s_addr / 16) * 16 + i] & s_lat[i];
            m_start = 0;
        end else if (m_start != 0) begin
            m_cnt = m_cnt - 1;
        end
        if (go) begin
            m_start = 1; m_cnt = CYC - 1; s_op = op; s_addr = m_addr;
            for (int i = 0; i < 16; i++) s_lat[i] = lat[i];
        end
        if (w) begin
            if (s == 3'd0) begin m_wen = int'(d[14]); m_op = op; end
            else if (s == 3'd2) m_addr = int'(d[5:0]);
            else if (s == 3'd4) begin lat[p % 16] = d; m_addr = int'(p); end
        end
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one clock: drive, compare against the model, advance both
    task automatic step(input logic w, input logic [2:0] s,
                        input logic [15:0] d, input logic [5:0] p);
        bus_wr = w; bus_sel = s; bus_wdata = d; bus_ptr = p;
        #1;
        last_rd = bus_rdata;
        check(cur_req, last_rd, model_rd(s));
        @(posedge clk);
        model_step(w, s, d, p);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        step(1'b1, s, d, 6'd0);
    endtask
    task automatic wr_lat(input logic [5:0] p, input logic [15:0] d);
        step(1'b1, 3'd4, d, p);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'd0, 6'd0);
    endtask
    task automatic rd(input logic [2:0] s);
        step(1'b0, s, 16'd0, 6'd0);
    endtask
    task automatic unlock();
        wr(3'd1, 16'h0055);
        wr(3'd1, 16'h00AA);
    endtask

    initial begin
        int hi;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        rd(3'd0); check("R1", last_rd, 16'h0000);
        rd(3'd3); check("R1", last_rd, 16'hFFFF);

        // R10 latch write captures pointer
        cur_req = "R10";
        wr_lat(6'd5, 16'h1234);
        rd(3'd2); check("R10", last_rd, 16'd5);
        rd(3'd4); check("R10", last_rd, 16'h1234);
        rd(3'd1); check("R10", last_rd, 16'h0000);

        // R8 / R4 word program, start length, done flag
        cur_req = "R4";
        wr(3'd0, 16'h4004);
        unlock();
        wr(3'd0, 16'hC004);
        hi = 0;
        for (int i = 0; i < CYC + 10; i++) begin
            rd(3'd0);
            if (last_rd[15]) hi++;
        end
        check("R4", 16'(hi), 16'(CYC));
        check("R4", last_rd & 16'hE000, 16'h6000);
        cur_req = "R8";
        rd(3'd3); check("R8", last_rd, 16'h1234);

        // R5 done sticky, then cleared
        cur_req = "R5";
        wr(3'd0, 16'h6004);
        rd(3'd0); check("R5", last_rd & 16'h2000, 16'h2000);
        wr(3'd0, 16'h4004);
        rd(3'd0); check("R5", last_rd & 16'h2000, 16'h0000);

        // R8 programming without erase only clears bits
        cur_req = "R8";
        wr_lat(6'd5, 16'hFF00);
        unlock();
        wr(3'd0, 16'hC004);
        idle(CYC + 2);
        rd(3'd3); check("R8", last_rd, 16'h1200);

        // R7 erase
        cur_req = "R7";
        wr(3'd0, 16'h4001);
        unlock();
        wr(3'd0, 16'hC001);
        idle(CYC + 2);
        rd(3'd3); check("R7", last_rd, 16'hFFFF);

        // R2 wrong order and interrupted sequence
        cur_req = "R2";
        wr(3'd1, 16'h00AA); wr(3'd1, 16'h0055); wr(3'd0, 16'hC004);
        rd(3'd0); check("R2", last_rd & 16'h8000, 16'h0000);
        wr(3'd1, 16'h0055); wr(3'd2, 16'h0005); wr(3'd1, 16'h00AA); wr(3'd0, 16'hC004);
        rd(3'd0); check("R2", last_rd & 16'h8000, 16'h0000);

        // R3 enable must be set earlier; attempt consumes unlock
        cur_req = "R3";
        wr(3'd0, 16'h0004);
        unlock();
        wr(3'd0, 16'hC004);
        rd(3'd0); check("R3", last_rd & 16'hC000, 16'h4000);
        wr(3'd0, 16'hC004);
        rd(3'd0); check("R3", last_rd & 16'h8000, 16'h0000);

        // R11 unknown operation code
        cur_req = "R11";
        unlock();
        wr(3'd0, 16'hC007);
        rd(3'd0); check("R11", last_rd & 16'h8000, 16'h0000);

        // R6 clearing enable mid-cycle does not abort
        cur_req = "R6";
        wr_lat(6'd5, 16'h0F0F);
        wr(3'd0, 16'h4004);
        unlock();
        wr(3'd0, 16'hC004);
        idle(3);
        wr(3'd0, 16'h0004);
        rd(3'd0); check("R6", last_rd & 16'hC000, 16'h8000);
        idle(CYC);
        rd(3'd3); check("R6", last_rd, 16'h0F0F);
        rd(3'd0); check("R6", last_rd & 16'h4000, 16'h0000);

        // R12 captured target survives bus writes during the cycle
        cur_req = "R12";
        wr(3'd0, 16'h4001);
        unlock();
        wr(3'd0, 16'hC001);
        idle(CYC + 2);
        wr_lat(6'd5, 16'hA5A5);
        wr(3'd0, 16'h4004);
        unlock();
        wr(3'd0, 16'hC004);
        wr_lat(6'd5, 16'h0000);
        wr_lat(6'd7, 16'h0000);
        idle(CYC);
        wr(3'd2, 16'd5);
        rd(3'd3); check("R12", last_rd, 16'hA5A5);
        wr(3'd2, 16'd7);
        rd(3'd3); check("R12", last_rd, 16'hFFFF);

        // R9 block program of words 16..31
        cur_req = "R9";
        for (int i = 0; i < 16; i++) wr_lat(6'(16 + i), 16'h0F00 + 16'(i * 17));
        wr(3'd0, 16'h4005);
        unlock();
        wr(3'd0, 16'hC005);
        idle(CYC + 2);
        for (int i = 0; i < 16; i++) begin
            wr(3'd2, 16'(16 + i));
            rd(3'd3); check("R9", last_rd, 16'h0F00 + 16'(i * 17));
        end
        wr(3'd2, 16'd32);
        rd(3'd3); check("R9", last_rd, 16'hFFFF);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule